// File: doc/BRIEF.md
# Byte-Addressed I2C Target with Row-Wrapping Pointer

This block is an I2C target that watches SCL and SDA as plain inputs sampled by a fast system clock, and pulls SDA low through a single drive-enable output. It answers a 7-bit device address. The upper four bits of that address are a fixed parameter and the lower three come from strap pins. Accepted transactions become single-cycle writes and pointer-addressed reads on a simple register-bank port. That port has a registered read with one cycle of latency.

A byte pointer inside the block sets where each access lands. In a write transaction, the first data byte loads the pointer. Each byte after that is stored at the pointer, and the pointer then steps within its 8-byte row. A read transaction returns data from the pointer and steps it across the whole byte space, so a host can read on from the current position. A host can also set the position with an address-only write followed by a repeated start. While the memory side signals that a nonvolatile commit is in progress, the block ignores its own address. A host can therefore poll for completion by retrying the address until it is acknowledged.

Top module: `i2c_pg_target`

## Requirements
- R1: The address byte is sent MSB first as the fixed prefix 4'b1010, then the three strap pins (dev_sel[2], dev_sel[1], dev_sel[0]), then the direction bit (0 = write, 1 = read). A match is acknowledged by pulling SDA low during the 9th clock.
- R2: If the address does not match, the block drives no SDA bit and makes no memory write until the next start condition.
- R3: In a write transaction, the first data byte loads the pointer. Each later byte causes exactly one mem_we pulse carrying the pointer and the byte, and the pointer then steps.
- R4: During writes, the pointer increments only its low 3 bits. Stepping past the end of a row returns it to the same row with those 3 bits cleared (0x1F is followed by 0x18).
- R5: While mem_busy is high when the address byte completes, the address is not acknowledged and no write follows.
- R6: A read returns the byte at the pointer, one byte per acknowledged master bit. It may start without a preceding pointer byte. An address-only write followed by a repeated start sets where the read begins.
- R7: During reads, the pointer steps across the full 8-bit space with no row wrap (0x07 is followed by 0x08, and 0xFF by 0x00).
- R8: After the master NACKs a read byte, the block releases SDA and sends nothing further.
- R9: Write-data bytes are acknowledged low in the 9th clock. SDA is changed by the block only after a falling SCL edge, and received bits are taken on the rising edge.
- R10: Start and stop are recognised at any bit position. A start in the middle of a byte restarts the address phase. A stop in the middle of a data byte discards that byte.
- R11: After reset, SDA is released and no write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled I2C clock line |
| sda_i | input | 1 | Sampled I2C data line |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| dev_sel | input | 3 | Strap pins forming the low three address bits |
| mem_addr | output | 8 | Pointer presented to the register bank |
| mem_wdata | output | 8 | Byte to store |
| mem_we | output | 1 | One-cycle write strobe |
| mem_rdata | input | 8 | Registered read data for mem_addr |
| mem_busy | input | 1 | High while a nonvolatile commit is in progress |

## Verification
The hardest cases to reach are the aborted ones: a start arriving after only a few address bits, and a stop arriving halfway through a data byte. Each must leave the pointer and the memory exactly as they were. The bench makes its master break off a byte at an arbitrary bit, issue the condition, and then perform a read from the current pointer. A stray write or pointer step would then appear as a wrong byte or as an unexpected entry in the write scoreboard. The busy case is reached the same way: the commit flag is raised, the master addresses the block and keeps clocking data, and the pointer is read back once the flag drops.

// File: rtl/i2c_pg_pkg.sv
package i2c_pg_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_pg_sync.sv
module i2c_pg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // data edges while the clock stays high
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_pg_addr_ctr.sv
module i2c_pg_addr_ctr #(
  parameter int AW        = 8,
  parameter int PAGE_BITS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          wr_step,
  input  logic          rd_step,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] wr_next;

  generate
    if (PAGE_BITS == 0) begin : g_flat
      assign wr_next = addr + 1'b1;
    end else begin : g_row
      localparam logic [PAGE_BITS-1:0] ROW_ONE = 1;
      logic [PAGE_BITS-1:0] low_next;
      assign low_next = addr[PAGE_BITS-1:0] + ROW_ONE;
      assign wr_next  = {addr[AW-1:PAGE_BITS], low_next};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          addr <= '0;
    else if (load)    addr <= load_val;
    else if (wr_step) addr <= wr_next;
    else if (rd_step) addr <= addr + 1'b1;
  end
endmodule

// File: rtl/i2c_pg_target.sv
module i2c_pg_target
  import i2c_pg_pkg::*;
#(
  parameter logic [3:0] DEV_PREFIX = 4'b1010,
  parameter int         SYNC_STAGES = 2,
  parameter int         PAGE_BITS   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        dev_sel,
  output logic [BYTE_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [BYTE_W-1:0] mem_rdata,
  input  logic              mem_busy
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  tgt_state_e state;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] rx_sr, tx_sr, ld_val;
  logic rw, first_byte, ack_bit, ctr_ld, rd_step;

  i2c_pg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  // a write strobe advances the pointer one cycle later
  i2c_pg_addr_ctr #(.AW(BYTE_W), .PAGE_BITS(PAGE_BITS)) u_ctr (
    .clk(clk), .rst(rst), .load(ctr_ld), .load_val(ld_val),
    .wr_step(mem_we), .rd_step(rd_step), .addr(mem_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      bitcnt     <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      ld_val     <= '0;
      rw         <= 1'b0;
      first_byte <= 1'b0;
      ack_bit    <= 1'b1;
      ctr_ld     <= 1'b0;
      rd_step    <= 1'b0;
      mem_we     <= 1'b0;
      mem_wdata  <= '0;
      sda_oe     <= 1'b0;
    end else begin
      ctr_ld  <= 1'b0;
      rd_step <= 1'b0;
      mem_we  <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              rx_sr  <= {rx_sr[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == LAST_BIT) begin
              if (rx_sr[BYTE_W-1:1] == {DEV_PREFIX, dev_sel} && !mem_busy) begin
                rw     <= rx_sr[0];
                sda_oe <= 1'b1;
                state  <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                tx_sr   <= mem_rdata;
                sda_oe  <= ~mem_rdata[BYTE_W-1];
                rd_step <= 1'b1;
                state   <= ST_RD;
              end else begin
                sda_oe     <= 1'b0;
                first_byte <= 1'b1;
                state      <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise) begin
              rx_sr  <= {rx_sr[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == LAST_BIT) begin
              sda_oe <= 1'b1;
              state  <= ST_WR_ACK;
              if (first_byte) begin
                ctr_ld     <= 1'b1;
                ld_val     <= rx_sr;
                first_byte <= 1'b0;
              end else begin
                mem_we    <= 1'b1;
                mem_wdata <= rx_sr;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                state  <= ST_RD_ACK;
              end else begin
                tx_sr  <= {tx_sr[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx_sr[BYTE_W-2];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              ack_bit <= sda_s;
            end else if (scl_fall) begin
              if (!ack_bit) begin
                tx_sr   <= mem_rdata;
                sda_oe  <= ~mem_rdata[BYTE_W-1];
                rd_step <= 1'b1;
                bitcnt  <= '0;
                state   <= ST_RD;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_pg_target_chk.sv
module i2c_pg_target_chk
  import i2c_pg_pkg::*;
#(
  parameter int PAGE_BITS = 3,
  parameter int CNT_W     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sda_oe,
  input logic              mem_we,
  input logic              mem_busy,
  input logic [BYTE_W-1:0] mem_addr,
  input logic              scl_fall,
  input logic              start_det,
  input logic              stop_det,
  input tgt_state_e        state,
  input logic [CNT_W-1:0]  bitcnt
);
  // R3
  we_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R4
  row_stays_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (mem_addr[BYTE_W-1:PAGE_BITS] == $past(mem_addr[BYTE_W-1:PAGE_BITS])));

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R5
  busy_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADDR && scl_fall && bitcnt == CNT_W'(BYTE_W) && mem_busy
     && !start_det && !stop_det) |=> !sda_oe);

  // R9
  drive_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> $past(scl_fall || start_det || stop_det));
endmodule

bind i2c_pg_target i2c_pg_target_chk #(.PAGE_BITS(PAGE_BITS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .mem_we(mem_we), .mem_busy(mem_busy),
  .mem_addr(mem_addr), .scl_fall(scl_fall), .start_det(start_det),
  .stop_det(stop_det), .state(state), .bitcnt(bitcnt)
);

// File: tb/i2c_pg_target_test.sv
module i2c_pg_target_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] sel = 3'b101;
  logic busy = 1'b0;
  logic sda_oe, mem_we;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic sda_bus;
  assign sda_bus = sda_m & ~sda_oe;

  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  logic [15:0] exp_q [$];
  logic [7:0] cur;
  int checks = 0, errors = 0, stray = 0;

  i2c_pg_target uut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .dev_sel(sel), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .mem_busy(busy)
  );

  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr];
    if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every write strobe must match the next queued item
  always @(negedge clk) begin
    logic [15:0] e;
    if (!rst && mem_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 R5 unexpected write", {mem_addr, mem_wdata}, 0);
      end else begin
        e = exp_q.pop_front();
        chk({mem_addr, mem_wdata} == e, "R3 write", {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q);
    sda_m = 1'b0; wclk(Q); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(Q); scl_m = 1'b1; wclk(Q);
    sda_m = 1'b1; wclk(2 * Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wclk(Q); scl_m = 1'b1; wclk(Q / 2);
    if (sda_oe) stray++;
    wclk(Q / 2); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wclk(Q); scl_m = 1'b1; wclk(Q / 2);
    b = sda_bus;
    wclk(Q / 2); scl_m = 1'b0; wclk(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    send_bit(!ack);
  endtask

  function automatic logic [7:0] dev_byte(input logic [2:0] pins, input logic rd);
    return {4'b1010, pins, rd};
  endfunction

  task automatic write_burst(input logic [7:0] a, input int n, input logic [7:0] seed);
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte(dev_byte(sel, 1'b0), ack);
    chk(ack, "R1 write address ack", ack, 1);
    send_byte(a, ack);
    chk(ack, "R9 pointer byte ack", ack, 1);
    cur = a;
    for (int i = 0; i < n; i++) begin
      d = seed + 8'(i * 7);
      exp_q.push_back({cur, d});
      ref_mem[cur] = d;
      send_byte(d, ack);
      chk(ack, "R9 data ack", ack, 1);
      cur = {cur[7:3], cur[2:0] + 3'd1};
    end
    bus_stop();
    wclk(20);
    chk(exp_q.size() == 0, "R4 writes all seen", exp_q.size(), 0);
  endtask

  task automatic read_burst(input bit set_ptr, input logic [7:0] a, input int n, input string tag);
    bit ack;
    logic [7:0] v;
    if (set_ptr) begin
      bus_start();
      send_byte(dev_byte(sel, 1'b0), ack);
      send_byte(a, ack);
      cur = a;
    end
    bus_start();
    send_byte(dev_byte(sel, 1'b1), ack);
    chk(ack, "R1 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(v, i != n - 1);
      chk(v == ref_mem[cur], tag, v, ref_mem[cur]);
      cur = cur + 8'd1;
    end
    wclk(2);
    chk(sda_oe == 1'b0, "R8 released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    logic b;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 5 + 3);
      ref_mem[i] = 8'(i * 5 + 3);
    end
    wclk(5);
    chk(sda_oe == 1'b0, "R11 sda released in reset", sda_oe, 0);
    chk(mem_we == 1'b0, "R11 no write in reset", mem_we, 0);
    rst = 1'b0;
    wclk(10);

    // R3 plain burst
    write_burst(8'h10, 3, 8'hA1);
    // R4 wrap 0x1D..0x1F then 0x18, 0x19
    write_burst(8'h1D, 5, 8'h40);
    // R6 read from current pointer (0x1A) with no pointer byte
    read_burst(1'b0, 8'h00, 2, "R6 current-pointer read");
    // R7 read crosses a row boundary
    read_burst(1'b1, 8'h06, 3, "R7 row crossing read");
    // R7 read wraps the byte space
    read_burst(1'b1, 8'hFE, 3, "R7 full wrap read");

    // R2 wrong strap pins and wrong prefix
    stray = 0;
    bus_start();
    send_byte(dev_byte(3'b100, 1'b0), ack);
    chk(!ack, "R2 wrong pins nack", ack, 0);
    send_byte(8'h22, ack);
    send_byte(8'h99, ack);
    bus_stop();
    bus_start();
    send_byte({4'b1011, sel, 1'b0}, ack);
    chk(!ack, "R2 wrong prefix nack", ack, 0);
    send_byte(8'h33, ack);
    bus_stop();
    chk(stray == 0, "R2 no drive while unaddressed", stray, 0);
    read_burst(1'b0, 8'h00, 1, "R2 pointer unchanged");

    // R5 busy: ignore address, then recover
    busy = 1'b1;
    bus_start();
    send_byte(dev_byte(sel, 1'b0), ack);
    chk(!ack, "R5 busy write nack", ack, 0);
    send_byte(8'h05, ack);
    send_byte(8'h77, ack);
    bus_stop();
    bus_start();
    send_byte(dev_byte(sel, 1'b1), ack);
    chk(!ack, "R5 busy read nack", ack, 0);
    bus_stop();
    busy = 1'b0;
    read_burst(1'b0, 8'h00, 1, "R5 pointer kept while busy");

    // R10 start in the middle of a byte restarts the address phase
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send_byte(dev_byte(sel, 1'b0), ack);
    chk(ack, "R10 ack after mid-byte start", ack, 1);
    send_byte(8'h40, ack);
    exp_q.push_back({8'h40, 8'h5A});
    ref_mem[8'h40] = 8'h5A;
    send_byte(8'h5A, ack);
    bus_stop();
    wclk(20);
    chk(exp_q.size() == 0, "R10 write after restart", exp_q.size(), 0);

    // R10 stop in the middle of a data byte discards it
    bus_start();
    send_byte(dev_byte(sel, 1'b0), ack);
    send_byte(8'h50, ack);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    cur = 8'h50;
    read_burst(1'b0, 8'h00, 2, "R10 aborted byte not stored");
    get_bit(b);
    chk(b == 1'b1, "R8 bus idle after read", b, 1);

    wclk(20);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule